// File: doc/BRIEF.md
# Privilege and Trap Controller

This block keeps track of whether a small in-order core runs in machine or user privilege. It decides in the same cycle whether the instruction presented by the pipeline traps, returns from a trap, waits for an interrupt or goes ahead. The pipeline hands it one decoded event per cycle: environment call, trap return, wait-for-interrupt, or CSR access with its address, direction and write data. Along with the event come the instruction PC and the pending and per-source enable lines of three interrupt sources. In return the block gives a trap request with its cause, a redirect with its target PC, a stall while waiting, the current privilege and the protection bit for data-bus accesses.

It holds a small status register (global interrupt enable, its saved copy, the saved privilege, a modify-privilege bit for data accesses and a bit that forbids waiting in user mode). It also holds the exception PC, the cause and a user counter-enable mask. Software in machine mode reads and writes these through the CSR port. Trap entry always jumps to one fixed vector address.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the hart is in machine mode, `o_stall`, `o_trap` and `o_redir` are low, `o_prot0` is high, and the status, cause, exception-PC and counter-enable registers all read 0.
- R2: A non-preempted ecall traps with cause 11 from machine mode or 8 from user mode. It records its own PC as exception PC, moves to machine mode and redirects to `TVEC_BASE`.
- R3: Every trap copies the privilege in effect before it into the saved-privilege field, copies the global enable into its saved copy, and clears the global enable.
- R4: A trap return in machine mode redirects to the exception PC and restores privilege from the saved field. It loads the global enable from its saved copy, sets the saved copy to 1 and sets the saved privilege to user. It clears the modify-privilege bit when returning to user mode.
- R5: In user mode, a trap return and any access to a CSR whose address bits 9:8 are 11 trap with cause 2 and record the faulting PC. The register is left unchanged.
- R6: In user mode, reads of 0xC00..0xC02 and 0xC80..0xC82 are allowed only when the counter-enable bit indexed by address bits 1:0 is set, and trap with cause 2 otherwise. A write to any address with bits 11:10 equal to 11 traps with cause 2 in either mode.
- R7: With the global enable set, wait-for-interrupt raises `o_stall` from the next cycle until an enabled interrupt is pending. It then traps with the interrupt cause and records the waiting PC plus 4.
- R8: With the global enable clear, wait-for-interrupt stalls until an enabled interrupt is pending. The stall then drops without any trap or redirect.
- R9: With the wait-forbid bit set, wait-for-interrupt in user mode traps with cause 2 in the same cycle and never stalls. In machine mode the bit has no effect.
- R10: When the global enable is set and some source is both pending and enabled, a trap is taken that cycle in place of the presented instruction, with the presented PC recorded. The cause has bit 31 set and code 11 (source 2), 3 (source 0) or 7 (source 1), in that priority.
- R11: While stalled, presented instructions are ignored: they cause no trap, redirect or register write.
- R12: `o_priv` is 1 in machine mode. `o_prot0` is 1 only in machine mode when the modify-privilege bit is clear or the saved privilege is machine.
- R13: CSR map: status at 0x300 (enable bit 3, saved enable bit 7, saved privilege bits 12:11 written from bit 12 and read as 00 or 11, modify-privilege bit 17, wait-forbid bit 21). Counter-enable is at 0x306 (bits 2:0), exception PC at 0x341 (bits 1:0 read 0) and cause at 0x342. `o_csr_rdata` shows the addressed register combinationally, with 0 for other addresses. `o_cause` and `o_redir_pc` are 0 when not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | An instruction event is presented |
| i_ecall | input | 1 | Event is an environment call |
| i_mret | input | 1 | Event is a trap return |
| i_wfi | input | 1 | Event is wait-for-interrupt |
| i_csr_en | input | 1 | Event is a CSR access |
| i_csr_wr | input | 1 | CSR access writes |
| i_csr_addr | input | 12 | CSR address |
| i_csr_wdata | input | XLEN | CSR write data |
| i_pc | input | XLEN | PC of the presented instruction |
| i_irq_pend | input | 3 | Interrupt pending lines |
| i_irq_en | input | 3 | Per-source interrupt enables |
| o_trap | output | 1 | Trap taken this cycle |
| o_cause | output | XLEN | Trap cause |
| o_redir | output | 1 | Fetch redirect this cycle |
| o_redir_pc | output | XLEN | Redirect target |
| o_stall | output | 1 | Waiting for an interrupt |
| o_priv | output | 1 | 1 = machine mode, 0 = user mode |
| o_prot0 | output | 1 | Data-bus privileged-access bit |
| o_csr_rdata | output | XLEN | CSR read data |

## Verification
Two collisions matter here. An interrupt can become pending and enabled in the same cycle that an ecall or a CSR write is presented. The bench raises the interrupt lines exactly on such cycles and expects the interrupt cause, the presented PC as exception PC and an untouched register on read-back. A waiting hart can also be presented with ecalls and CSR writes while the wake-up arrives. The bench judges each such cycle against a behavioural model that advances on every clock and compares all outputs. It also uses a long random phase that mixes interrupts with every kind of instruction event.

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] TVEC_BASE = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            i_valid,
  input  logic            i_ecall,
  input  logic            i_mret,
  input  logic            i_wfi,
  input  logic            i_csr_en,
  input  logic            i_csr_wr,
  input  logic [11:0]     i_csr_addr,
  input  logic [XLEN-1:0] i_csr_wdata,
  input  logic [XLEN-1:0] i_pc,
  input  logic [2:0]      i_irq_pend,
  input  logic [2:0]      i_irq_en,
  output logic            o_trap,
  output logic [XLEN-1:0] o_cause,
  output logic            o_redir,
  output logic [XLEN-1:0] o_redir_pc,
  output logic            o_stall,
  output logic            o_priv,
  output logic            o_prot0,
  output logic [XLEN-1:0] o_csr_rdata
);

  localparam logic [11:0] A_STATUS = 12'h300;
  localparam logic [11:0] A_CTREN  = 12'h306;
  localparam logic [11:0] A_EPC    = 12'h341;
  localparam logic [11:0] A_CAUSE  = 12'h342;
  localparam int B_MIE = 3, B_MPIE = 7, B_MPP = 12, B_MPRV = 17, B_TW = 21;

  logic            priv_m, st_mie, st_mpie, st_mpp_m, st_mprv, st_tw;
  logic [XLEN-1:0] epc_q, cause_q, wpc_q;
  logic [2:0]      cen_q;
  logic            wait_q;

  logic [2:0] irq_hit;
  logic       irq_any, irq_take;
  logic [3:0] irq_code;
  assign irq_hit  = i_irq_pend & i_irq_en;
  assign irq_any  = |irq_hit;
  assign irq_take = st_mie && irq_any;
  assign irq_code = irq_hit[2] ? 4'd11 : irq_hit[0] ? 4'd3 : 4'd7;

  logic exec, is_ctr, csr_bad, illegal, ecall_take, mret_do, wfi_go, csr_wr_do;
  logic [3:0] cen_x;
  assign cen_x  = {1'b0, cen_q};
  assign exec   = i_valid && !wait_q && !irq_take;
  assign is_ctr = (i_csr_addr[11:8] == 4'hC) && (i_csr_addr[6:2] == 5'd0) &&
                  (i_csr_addr[1:0] != 2'd3);
  assign csr_bad = i_csr_en && ((i_csr_wr && (&i_csr_addr[11:10])) ||
                                (!priv_m && (&i_csr_addr[9:8])) ||
                                (!priv_m && is_ctr && !cen_x[i_csr_addr[1:0]]));
  assign illegal    = exec && ((i_mret && !priv_m) || (i_wfi && !priv_m && st_tw) || csr_bad);
  assign ecall_take = exec && i_ecall && !illegal;
  assign mret_do    = exec && i_mret && !illegal;
  assign wfi_go     = exec && i_wfi && !illegal;
  assign csr_wr_do  = exec && i_csr_en && i_csr_wr && !illegal;

  logic [XLEN-1:0] cause_nx, trap_epc, status_rd;
  assign cause_nx = irq_take ? {1'b1, {(XLEN-5){1'b0}}, irq_code} :
                    illegal  ? XLEN'(2) :
                    priv_m   ? XLEN'(11) : XLEN'(8);
  assign trap_epc = wait_q ? wpc_q + XLEN'(4) : i_pc;

  assign o_trap     = irq_take || illegal || ecall_take;
  assign o_cause    = o_trap ? cause_nx : '0;
  assign o_redir    = o_trap || mret_do;
  assign o_redir_pc = o_trap ? TVEC_BASE : mret_do ? epc_q : '0;
  assign o_stall    = wait_q && !irq_any;
  assign o_priv     = priv_m;
  assign o_prot0    = priv_m && !(st_mprv && !st_mpp_m);

  always_comb begin
    status_rd         = '0;
    status_rd[B_MIE]  = st_mie;
    status_rd[B_MPIE] = st_mpie;
    status_rd[B_MPP]  = st_mpp_m;
    status_rd[B_MPP-1] = st_mpp_m;
    status_rd[B_MPRV] = st_mprv;
    status_rd[B_TW]   = st_tw;
  end

  always_comb begin
    case (i_csr_addr)
      A_STATUS: o_csr_rdata = status_rd;
      A_CTREN:  o_csr_rdata = XLEN'(cen_q);
      A_EPC:    o_csr_rdata = epc_q;
      A_CAUSE:  o_csr_rdata = cause_q;
      default:  o_csr_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_m   <= 1'b1;
      st_mie   <= 1'b0;
      st_mpie  <= 1'b0;
      st_mpp_m <= 1'b0;
      st_mprv  <= 1'b0;
      st_tw    <= 1'b0;
      epc_q    <= '0;
      cause_q  <= '0;
      wpc_q    <= '0;
      cen_q    <= '0;
      wait_q   <= 1'b0;
    end else if (o_trap) begin
      epc_q    <= trap_epc;
      cause_q  <= cause_nx;
      st_mpie  <= st_mie;
      st_mie   <= 1'b0;
      st_mpp_m <= priv_m;
      priv_m   <= 1'b1;
      wait_q   <= 1'b0;
    end else begin
      if (wait_q && irq_any) wait_q <= 1'b0;
      if (mret_do) begin
        priv_m   <= st_mpp_m;
        st_mie   <= st_mpie;
        st_mpie  <= 1'b1;
        st_mpp_m <= 1'b0;
        if (!st_mpp_m) st_mprv <= 1'b0;
      end
      if (wfi_go) begin
        wait_q <= 1'b1;
        wpc_q  <= i_pc;
      end
      if (csr_wr_do) begin
        case (i_csr_addr)
          A_STATUS: begin
            st_mie   <= i_csr_wdata[B_MIE];
            st_mpie  <= i_csr_wdata[B_MPIE];
            st_mpp_m <= i_csr_wdata[B_MPP];
            st_mprv  <= i_csr_wdata[B_MPRV];
            st_tw    <= i_csr_wdata[B_TW];
          end
          A_CTREN: cen_q   <= i_csr_wdata[2:0];
          A_EPC:   epc_q   <= {i_csr_wdata[XLEN-1:2], 2'b00};
          A_CAUSE: cause_q <= i_csr_wdata;
          default: ;
        endcase
      end
    end
  end

endmodule

module priv_trap_chk #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] TVEC_BASE = 32'h0000_0100
) (
  input logic            clk,
  input logic            rst_n,
  input logic            i_valid,
  input logic            i_ecall,
  input logic            i_mret,
  input logic [2:0]      i_irq_pend,
  input logic [2:0]      i_irq_en,
  input logic            o_trap,
  input logic [XLEN-1:0] o_cause,
  input logic            o_redir,
  input logic [XLEN-1:0] o_redir_pc,
  input logic            o_stall,
  input logic            o_priv,
  input logic            o_prot0
);

  logic quiet_irq;
  assign quiet_irq = ((i_irq_pend & i_irq_en) == 3'b000);

  AST_TRAP_TO_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
    o_trap |=> o_priv); // R2
  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    o_trap |-> (o_redir && o_redir_pc == TVEC_BASE)); // R2
  AST_ECALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_ecall && !o_stall && quiet_irq) |->
      (o_trap && o_cause == (o_priv ? XLEN'(11) : XLEN'(8)))); // R2
  AST_USER_MRET_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!o_priv && i_valid && i_mret && !o_stall && quiet_irq) |->
      (o_trap && o_cause == XLEN'(2))); // R5
  AST_IRQ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_trap && o_cause[XLEN-1]) |->
      (o_cause[XLEN-2:0] == 3 || o_cause[XLEN-2:0] == 7 || o_cause[XLEN-2:0] == 11)); // R10
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    o_stall |-> !o_redir); // R11
  AST_USER_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    !o_priv |-> !o_prot0); // R12

endmodule

bind priv_trap_ctrl priv_trap_chk #(.XLEN(XLEN), .TVEC_BASE(TVEC_BASE)) u_chk (.*);

// File: tb/tb_priv_trap_ctrl.sv
module tb_priv_trap_ctrl;
  localparam logic [31:0] TVEC = 32'h0000_0100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        i_valid = 0, i_ecall = 0, i_mret = 0, i_wfi = 0, i_csr_en = 0, i_csr_wr = 0;
  logic [11:0] i_csr_addr = '0;
  logic [31:0] i_csr_wdata = '0, i_pc = '0;
  logic [2:0]  i_irq_pend = '0, i_irq_en = '0;
  logic        o_trap, o_redir, o_stall, o_priv, o_prot0;
  logic [31:0] o_cause, o_redir_pc, o_csr_rdata;

  priv_trap_ctrl #(.XLEN(32), .TVEC_BASE(TVEC)) dut (.*);

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state
  bit m_priv, m_mie, m_mpie, m_mppm, m_mprv, m_tw, m_wait;
  logic [31:0] m_epc, m_cause, m_wpc;
  logic [2:0] m_cen;
  logic [2:0] g_pend = 0, g_en = 0;

  task automatic model_reset();
    m_priv = 1; m_mie = 0; m_mpie = 0; m_mppm = 0; m_mprv = 0; m_tw = 0; m_wait = 0;
    m_epc = 0; m_cause = 0; m_wpc = 0; m_cen = 0;
  endtask

  function automatic logic [31:0] m_read(logic [11:0] a);
    logic [31:0] s;
    case (a)
      12'h300: begin
        s = 0;
        if (m_mie)  s = s + 32'h8;
        if (m_mpie) s = s + 32'h80;
        if (m_mppm) s = s + 32'h1800;
        if (m_mprv) s = s + 32'h2_0000;
        if (m_tw)   s = s + 32'h20_0000;
        return s;
      end
      12'h306: return {29'd0, m_cen};
      12'h341: return m_epc;
      12'h342: return m_cause;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, nm, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit v, bit ec, bit mr, bit wf, bit ce, bit cw,
                      logic [11:0] a, logic [31:0] wd, logic [31:0] pc);
    bit any, trap, redir, stall, illegal, is_ctr, enter_wait, resume, do_mret, do_wr;
    logic [31:0] cause, rpc, epc;
    logic [3:0] code;
    logic [2:0] hit;
    @(posedge clk);
    #1;
    i_valid = v; i_ecall = ec; i_mret = mr; i_wfi = wf; i_csr_en = ce; i_csr_wr = cw;
    i_csr_addr = a; i_csr_wdata = wd; i_pc = pc; i_irq_pend = g_pend; i_irq_en = g_en;
    @(negedge clk);
    hit = g_pend & g_en;
    any = (hit != 0);
    code = hit[2] ? 11 : (hit[0] ? 3 : 7);
    trap = 0; redir = 0; stall = 0; illegal = 0; enter_wait = 0; resume = 0;
    do_mret = 0; do_wr = 0; cause = 0; rpc = 0; epc = pc;
    if (m_mie && any) begin
      trap = 1; cause = 32'h8000_0000 + 32'(code);
      epc = m_wait ? m_wpc + 4 : pc;
    end else if (m_wait) begin
      if (any) resume = 1; else stall = 1;
    end else if (v) begin
      if (ec) begin
        trap = 1; cause = m_priv ? 11 : 8;
      end else if (mr) begin
        if (!m_priv) illegal = 1; else do_mret = 1;
      end else if (wf) begin
        if (!m_priv && m_tw) illegal = 1; else enter_wait = 1;
      end else if (ce) begin
        is_ctr = (a == 12'hC00 || a == 12'hC01 || a == 12'hC02 ||
                  a == 12'hC80 || a == 12'hC81 || a == 12'hC82);
        if (cw && a[11:10] == 2'b11) illegal = 1;
        if (!m_priv && a[9:8] == 2'b11) illegal = 1;
        if (!m_priv && is_ctr && !m_cen[a[1:0]]) illegal = 1;
        if (!illegal && cw) do_wr = 1;
      end
      if (illegal) begin trap = 1; cause = 2; end
    end
    if (trap) begin redir = 1; rpc = TVEC; end
    else if (do_mret) begin redir = 1; rpc = m_epc; end
    chk(tag, "trap", 32'(o_trap), 32'(trap));
    chk(tag, "cause", o_cause, cause);
    chk(tag, "redir", 32'(o_redir), 32'(redir));
    chk(tag, "redir_pc", o_redir_pc, rpc);
    chk(tag, "stall", 32'(o_stall), 32'(stall));
    chk(tag, "priv", 32'(o_priv), 32'(m_priv));
    chk(tag, "prot0", 32'(o_prot0), 32'(m_priv && !(m_mprv && !m_mppm)));
    chk(tag, "csr_rdata", o_csr_rdata, m_read(a));
    if (trap) begin
      m_epc = epc; m_cause = cause; m_mpie = m_mie; m_mie = 0;
      m_mppm = m_priv; m_priv = 1; m_wait = 0;
    end else begin
      if (resume) m_wait = 0;
      if (do_mret) begin
        if (!m_mppm) m_mprv = 0;
        m_priv = m_mppm; m_mie = m_mpie; m_mpie = 1; m_mppm = 0;
      end
      if (enter_wait) begin m_wait = 1; m_wpc = pc; end
      if (do_wr) begin
        case (a)
          12'h300: begin
            m_mie = wd[3]; m_mpie = wd[7]; m_mppm = wd[12]; m_mprv = wd[17]; m_tw = wd[21];
          end
          12'h306: m_cen = wd[2:0];
          12'h341: m_epc = wd & 32'hFFFF_FFFC;
          12'h342: m_cause = wd;
          default: ;
        endcase
      end
    end
  endtask

  task automatic idle(string tag);           step(tag, 0,0,0,0,0,0, 12'h0, 0, 0); endtask
  task automatic rd(string tag, logic [11:0] a, logic [31:0] pc); step(tag, 1,0,0,0,1,0, a, 0, pc); endtask
  task automatic wr(string tag, logic [11:0] a, logic [31:0] d, logic [31:0] pc); step(tag, 1,0,0,0,1,1, a, d, pc); endtask
  task automatic ecall(string tag, logic [31:0] pc); step(tag, 1,1,0,0,0,0, 12'h0, 0, pc); endtask
  task automatic mret(string tag, logic [31:0] pc);  step(tag, 1,0,1,0,0,0, 12'h0, 0, pc); endtask
  task automatic wfi(string tag, logic [31:0] pc);   step(tag, 1,0,0,1,0,0, 12'h0, 0, pc); endtask

  initial begin : watchdog
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    idle("R1"); idle("R1");
    rd("R1", 12'h300, 32'h10); rd("R1", 12'h306, 32'h10);
    rd("R1", 12'h341, 32'h10); rd("R1", 12'h342, 32'h10);
    // R13 field layout
    wr("R13", 12'h300, 32'h0022_0888, 32'h14); rd("R13", 12'h300, 32'h18);
    wr("R13", 12'h300, 32'h0000_1000, 32'h1c); rd("R13", 12'h300, 32'h20);
    wr("R13", 12'h341, 32'h0000_1237, 32'h24); rd("R13", 12'h341, 32'h28);
    wr("R13", 12'h306, 32'hFFFF_FFFF, 32'h2c); rd("R13", 12'h306, 32'h30);
    wr("R13", 12'h342, 32'h55, 32'h34); rd("R13", 12'h342, 32'h38);
    rd("R13", 12'h123, 32'h3c);
    // R2 machine ecall
    ecall("R2", 32'h40); rd("R2", 12'h342, 32'h100); rd("R2", 12'h341, 32'h104);
    // R3 trap saves state
    wr("R3", 12'h300, 32'h8, 32'h108); ecall("R3", 32'h44); rd("R3", 12'h300, 32'h100);
    // R12 / R4 / R2 from user
    wr("R12", 12'h300, 32'h0002_0080, 32'h104); idle("R12");
    wr("R4", 12'h341, 32'h2000, 32'h108); mret("R4", 32'h48);
    idle("R12"); ecall("R2", 32'h2000); rd("R4", 12'h300, 32'h100);
    // R5 illegal in user
    wr("R5", 12'h300, 32'h0, 32'h104); wr("R5", 12'h341, 32'h3000, 32'h108);
    mret("R5", 32'h10c); mret("R5", 32'h3000); rd("R5", 12'h341, 32'h100);
    mret("R5", 32'h104); rd("R5", 12'h300, 32'h3004);
    mret("R5", 32'h100); wr("R5", 12'h341, 32'h0, 32'h3004); rd("R5", 12'h341, 32'h100);
    // R6 counter gating
    wr("R6", 12'h306, 32'h5, 32'h104); mret("R6", 32'h108);
    rd("R6", 12'hC00, 32'h3004); rd("R6", 12'hC02, 32'h3004); rd("R6", 12'hC01, 32'h3004);
    mret("R6", 32'h100); rd("R6", 12'hC81, 32'h3004); rd("R6", 12'hC82, 32'h100);
    wr("R6", 12'hC00, 32'h1, 32'h104); rd("R6", 12'h342, 32'h100);
    // R9 wait-forbid bit
    wr("R9", 12'h300, 32'h0020_0000, 32'h104); wr("R9", 12'h341, 32'h3000, 32'h108);
    mret("R9", 32'h10c); wfi("R9", 32'h3000); idle("R9");
    // R8 machine wfi with enable clear (TW set has no effect in machine mode)
    wfi("R8", 32'h60); g_pend = 3'b001; g_en = 3'b000; idle("R8"); idle("R8");
    g_en = 3'b001; idle("R8"); g_pend = 0; g_en = 0; idle("R8");
    // R11 inputs ignored while waiting
    wfi("R11", 32'h64); ecall("R11", 32'h68); wr("R11", 12'h300, 32'h8, 32'h68);
    mret("R11", 32'h68); g_pend = 3'b010; g_en = 3'b010; idle("R11");
    g_pend = 0; g_en = 0; rd("R11", 12'h300, 32'h68);
    // R7 machine wfi with enable set
    wr("R7", 12'h300, 32'h8, 32'h6c); wfi("R7", 32'h70); idle("R7"); idle("R7");
    g_pend = 3'b010; g_en = 3'b010; idle("R7"); g_pend = 0; g_en = 0;
    rd("R7", 12'h342, 32'h100); rd("R7", 12'h341, 32'h104);
    // R7 user wfi with enable set
    wr("R7", 12'h300, 32'h80, 32'h108); wr("R7", 12'h341, 32'h3000, 32'h10c);
    mret("R7", 32'h110); wfi("R7", 32'h3004); idle("R7");
    g_pend = 3'b100; g_en = 3'b100; idle("R7"); g_pend = 0; g_en = 0;
    rd("R7", 12'h341, 32'h100); rd("R7", 12'h300, 32'h100);
    // R10 interrupt preemption and priority
    wr("R10", 12'h300, 32'h8, 32'h104);
    g_pend = 3'b111; g_en = 3'b111; ecall("R10", 32'h80); g_pend = 0; g_en = 0;
    rd("R10", 12'h341, 32'h100);
    wr("R10", 12'h300, 32'h8, 32'h104);
    g_pend = 3'b011; g_en = 3'b011; wr("R10", 12'h341, 32'hABC, 32'h90); g_pend = 0; g_en = 0;
    rd("R10", 12'h341, 32'h100);
    wr("R10", 12'h300, 32'h8, 32'h104);
    g_pend = 3'b100; g_en = 3'b011; idle("R10");
    g_pend = 3'b010; g_en = 3'b010; idle("R10"); g_pend = 0; g_en = 0;
    rd("R10", 12'h342, 32'h100);
    // random mix, every output compared each cycle
    for (int k = 0; k < 2000; k++) begin
      logic [11:0] addrs [12];
      int sel;
      logic [31:0] pc, wd;
      addrs = '{12'h300, 12'h306, 12'h341, 12'h342, 12'hC00, 12'hC01,
                12'hC02, 12'hC03, 12'hC80, 12'hC82, 12'hB00, 12'h100};
      pc = {$urandom_range(0, 32'h3FFF), 2'b00};
      wd = $urandom;
      if ($urandom_range(0, 9) == 0) begin
        g_pend = 3'($urandom_range(0, 7)); g_en = 3'($urandom_range(0, 7));
      end else begin
        g_pend = 0; g_en = 0;
      end
      sel = $urandom_range(0, 9);
      case (sel)
        0: idle("R10");
        1: ecall("R2", pc);
        2, 3: mret("R4", pc);
        4: wfi("R7", pc);
        5, 6: rd("R6", addrs[$urandom_range(0, 11)], pc);
        default: wr("R13", addrs[$urandom_range(0, 11)], wd, pc);
      endcase
    end
    g_pend = 0; g_en = 0; idle("R1");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule